// File: doc/BRIEF.md
# Windowed Power-Good Qualifier

This block produces a single power-good bit for a regulated supply. A digitized output-voltage code is compared against a window placed around a target code. The window is asymmetric: its upper and lower edges are each set by a fractional percentage of the target. Power-good rises only after three things are true: the measured code is inside the window, no fault is flagged, and both conditions have held for a programmable number of delay ticks. Ticks come from a free-running prescaler outside the block, nominally one per microsecond.

The percentages and the delay sit in small writable registers inside the block. Each register reloads its default on reset: +15 % above the target, -10 % below it, and 1000 ticks, which is 1 ms at the nominal tick rate. If any condition drops while the delay is running, the tick count clears, and qualification starts again from zero the next time all conditions hold. Once power-good is high, it drops combinationally in the same cycle that any condition fails.

Top module: `pgood_window`

## Requirements
- R1: While `rstN` is low, `pgood` is low. Leaving reset, `pgood` is low and the tick count is zero.
- R2: The upper edge is `target + floor(target*upPct/1024)`, where `upPct` is an unsigned Q0.10 fraction whose default is 154. A code equal to the upper edge is inside the window, and one above it is outside.
- R3: The lower edge is `target - floor(target*loPct/1024)`, where `loPct` is an unsigned Q0.10 fraction whose default is 102. A code equal to the lower edge is inside the window, and one below it is outside.
- R4: A one-cycle pulse on `upWrEn`, `loWrEn` or `dlyWrEn` loads the paired value into that register. The new value governs behaviour from the next clock edge on.
- R5: While `fault` is high, `pgood` is low. If `fault` rises while `pgood` is high, `pgood` falls in the same cycle.
- R6: With a programmed delay of D ticks and `tick` high on every cycle, `pgood` rises D+2 clock edges after the first edge at which the conditions hold, and is low before that.
- R7: After reset the delay register holds 1000.
- R8: If the conditions fail at any edge during qualification, the count restarts from zero. A full D+2 edges of held conditions are then needed again.
- R9: When the voltage code leaves the window while `pgood` is high, `pgood` falls combinationally in the same cycle, with no clock edge in between.
- R10: Only cycles with `tick` high advance the count. With `tick` low, held conditions never raise `pgood`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Delay-resolution strobe from a prescaler |
| voutCode | input | 12 | Measured output-voltage code |
| targetCode | input | 12 | Target voltage code |
| fault | input | 1 | Fault flag; high blocks power-good |
| upWrEn | input | 1 | Write strobe for the upper percentage |
| upWrVal | input | 10 | Upper percentage, Q0.10 |
| loWrEn | input | 1 | Write strobe for the lower percentage |
| loWrVal | input | 10 | Lower percentage, Q0.10 |
| dlyWrEn | input | 1 | Write strobe for the delay |
| dlyWrVal | input | 16 | Delay in ticks |
| pgood | output | 1 | Power-good |

## Verification
The checker works out the window from the live percentage registers and the target code. It therefore assumes that `targetCode` and `voutCode` change only between clock edges and stay steady across each edge. The bench drives every input at the falling edge to meet this. The checker also assumes that `fault` and the window inputs carry no glitches. For this reason the bench checks the combinational deassertion with a short settle after the falling-edge drive, rather than at an active edge. Percentages are kept below 1.0, so the lower edge never wraps; every register value the bench writes keeps to this.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_QUAL = 2'd1,
    PG_GOOD = 2'd2
  } pgState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } pgStrobe_t;
endpackage

// File: rtl/pgood_regs.sv
module pgood_regs #(
  parameter int PCT_W         = 10,
  parameter int DLY_W         = 16,
  parameter int DEF_UPPER_PCT = 154,
  parameter int DEF_LOWER_PCT = 102,
  parameter int DEF_DELAY     = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upWrEn,
  input  logic [PCT_W-1:0] upWrVal,
  input  logic             loWrEn,
  input  logic [PCT_W-1:0] loWrVal,
  input  logic             dlyWrEn,
  input  logic [DLY_W-1:0] dlyWrVal,
  output logic [PCT_W-1:0] upperPct,
  output logic [PCT_W-1:0] lowerPct,
  output logic [DLY_W-1:0] delayTicks
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperPct   <= PCT_W'(DEF_UPPER_PCT);
      lowerPct   <= PCT_W'(DEF_LOWER_PCT);
      delayTicks <= DLY_W'(DEF_DELAY);
    end else begin
      if (upWrEn)  upperPct   <= upWrVal;
      if (loWrEn)  lowerPct   <= loWrVal;
      if (dlyWrEn) delayTicks <= dlyWrVal;
    end
  end
endmodule

// File: rtl/pgood_datapath.sv
module pgood_datapath
  import pgood_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PCT_W  = 10,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] voutCode,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              fault,
  input  logic [PCT_W-1:0]  upperPct,
  input  logic [PCT_W-1:0]  lowerPct,
  input  logic [DLY_W-1:0]  delayTicks,
  input  pgStrobe_t         strb,
  output logic              condOk,
  output logic              cntDone
);
  localparam int PROD_W = CODE_W + PCT_W;
  localparam int EDGE_W = CODE_W + 1;

  logic [PROD_W-1:0] upProd, loProd;
  logic [CODE_W-1:0] upDelta, loDelta;
  logic [EDGE_W-1:0] upEdge, loEdge, voutExt;
  logic              inWindow;
  logic [DLY_W-1:0]  tickCnt;

  always_comb begin
    upProd   = PROD_W'(targetCode) * PROD_W'(upperPct);
    loProd   = PROD_W'(targetCode) * PROD_W'(lowerPct);
    upDelta  = upProd[PROD_W-1:PCT_W];
    loDelta  = loProd[PROD_W-1:PCT_W];
    upEdge   = EDGE_W'(targetCode) + EDGE_W'(upDelta);
    loEdge   = EDGE_W'(targetCode) - EDGE_W'(loDelta);
    voutExt  = EDGE_W'(voutCode);
    inWindow = (voutExt >= loEdge) && (voutExt <= upEdge);
    condOk   = inWindow && !fault;
    cntDone  = (tickCnt >= delayTicks);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (strb.cntClr) tickCnt <= '0;
    else if (strb.cntInc) tickCnt <= tickCnt + 1'b1;
  end
endmodule

// File: rtl/pgood_ctrl.sv
module pgood_ctrl
  import pgood_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      condOk,
  input  logic      tick,
  input  logic      cntDone,
  output pgStrobe_t strb,
  output logic      isGood
);
  pgState_t state, nextState;

  always_comb begin
    nextState   = state;
    strb.cntClr = 1'b0;
    strb.cntInc = 1'b0;
    unique case (state)
      PG_IDLE: begin
        if (condOk) begin
          nextState   = PG_QUAL;
          strb.cntClr = 1'b1;
        end
      end
      PG_QUAL: begin
        if (!condOk) begin
          nextState   = PG_IDLE;
          strb.cntClr = 1'b1;
        end else if (cntDone) begin
          nextState = PG_GOOD;
        end else if (tick) begin
          strb.cntInc = 1'b1;
        end
      end
      PG_GOOD: begin
        if (!condOk) begin
          nextState   = PG_IDLE;
          strb.cntClr = 1'b1;
        end
      end
      default: begin
        nextState   = PG_IDLE;
        strb.cntClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PG_IDLE;
    else       state <= nextState;
  end

  assign isGood = (state == PG_GOOD);
endmodule

// File: rtl/pgood_window.sv
module pgood_window
  import pgood_pkg::*;
#(
  parameter int CODE_W        = 12,
  parameter int PCT_W         = 10,
  parameter int DLY_W         = 16,
  parameter int DEF_UPPER_PCT = 154,
  parameter int DEF_LOWER_PCT = 102,
  parameter int DEF_DELAY     = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CODE_W-1:0] voutCode,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              fault,
  input  logic              upWrEn,
  input  logic [PCT_W-1:0]  upWrVal,
  input  logic              loWrEn,
  input  logic [PCT_W-1:0]  loWrVal,
  input  logic              dlyWrEn,
  input  logic [DLY_W-1:0]  dlyWrVal,
  output logic              pgood
);
  logic [PCT_W-1:0] upperPct, lowerPct;
  logic [DLY_W-1:0] delayTicks;
  logic             condOk, cntDone, isGood;
  pgStrobe_t        strb;

  pgood_regs #(
    .PCT_W(PCT_W), .DLY_W(DLY_W), .DEF_UPPER_PCT(DEF_UPPER_PCT),
    .DEF_LOWER_PCT(DEF_LOWER_PCT), .DEF_DELAY(DEF_DELAY)
  ) uRegs (
    .clk(clk), .rstN(rstN),
    .upWrEn(upWrEn), .upWrVal(upWrVal),
    .loWrEn(loWrEn), .loWrVal(loWrVal),
    .dlyWrEn(dlyWrEn), .dlyWrVal(dlyWrVal),
    .upperPct(upperPct), .lowerPct(lowerPct), .delayTicks(delayTicks)
  );

  pgood_datapath #(.CODE_W(CODE_W), .PCT_W(PCT_W), .DLY_W(DLY_W)) uDp (
    .clk(clk), .rstN(rstN),
    .voutCode(voutCode), .targetCode(targetCode), .fault(fault),
    .upperPct(upperPct), .lowerPct(lowerPct), .delayTicks(delayTicks),
    .strb(strb), .condOk(condOk), .cntDone(cntDone)
  );

  pgood_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .condOk(condOk), .tick(tick),
    .cntDone(cntDone), .strb(strb), .isGood(isGood)
  );

  // fast release: qualified state gated by the live condition
  assign pgood = isGood && condOk;
endmodule

// File: rtl/pgood_window_chk.sv
module pgood_window_chk #(
  parameter int CODE_W = 12,
  parameter int PCT_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] voutCode,
  input logic [CODE_W-1:0] targetCode,
  input logic              fault,
  input logic [PCT_W-1:0]  upperPct,
  input logic [PCT_W-1:0]  lowerPct,
  input logic              pgood
);
  localparam int WIDE = CODE_W + PCT_W + 1;
  logic [WIDE-1:0] scaledV, scaledHi, scaledLo;
  logic            chkOk;

  // window test done in scaled form: vout*2^P compared with target*(2^P +/- pct), floored
  always_comb begin
    scaledV  = WIDE'(voutCode) << PCT_W;
    scaledHi = (WIDE'(targetCode) << PCT_W)
             + ((WIDE'(targetCode) * WIDE'(upperPct)) >> PCT_W << PCT_W);
    scaledLo = (WIDE'(targetCode) << PCT_W)
             - ((WIDE'(targetCode) * WIDE'(lowerPct)) >> PCT_W << PCT_W);
    chkOk    = (scaledV <= scaledHi) && (scaledV >= scaledLo) && !fault;
  end

  always @(posedge clk)
    if (!rstN) AST_LOW_IN_RESET: assert (!pgood); // R1

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !pgood); // R5

  AST_UPPER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> (scaledV <= scaledHi)); // R2

  AST_LOWER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    pgood |-> (scaledV >= scaledLo)); // R3

  AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgood) |-> $past(chkOk)); // R6

  AST_FALL_ON_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgood) |-> !chkOk || !$past(chkOk)); // R9
endmodule

bind pgood_window pgood_window_chk #(.CODE_W(CODE_W), .PCT_W(PCT_W)) uChk (
  .clk(clk), .rstN(rstN), .voutCode(voutCode), .targetCode(targetCode),
  .fault(fault), .upperPct(upperPct), .lowerPct(lowerPct), .pgood(pgood)
);

// File: tb/pgood_window_test.sv
module pgood_window_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {target, vout, fault, expected pgood} with default window, delay 0
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {12'd1000, 12'd1150, 1'b0, 1'b1},  // R2 upper edge inside
    {12'd1000, 12'd1151, 1'b0, 1'b0},  // R2 above upper edge
    {12'd1000, 12'd901,  1'b0, 1'b1},  // R3 lower edge inside
    {12'd1000, 12'd900,  1'b0, 1'b0},  // R3 below lower edge
    {12'd1000, 12'd1000, 1'b1, 1'b0},  // R5 fault
    {12'd2000, 12'd2300, 1'b0, 1'b1},  // R2
    {12'd2000, 12'd1800, 1'b0, 1'b0},  // R3
    {12'd4095, 12'd4095, 1'b0, 1'b1}   // R2 full scale
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic [11:0] voutCode = '0;
  logic [11:0] targetCode = 12'd1000;
  logic        fault = 1'b0;
  logic        upWrEn = 1'b0, loWrEn = 1'b0, dlyWrEn = 1'b0;
  logic [9:0]  upWrVal = '0, loWrVal = '0;
  logic [15:0] dlyWrVal = '0;
  logic        pgood;
  int          errCnt = 0;
  int          chkCnt = 0;
  bit          finished = 1'b0;

  pgood_window uut (
    .clk(clk), .rstN(rstN), .tick(tick), .voutCode(voutCode),
    .targetCode(targetCode), .fault(fault),
    .upWrEn(upWrEn), .upWrVal(upWrVal), .loWrEn(loWrEn), .loWrVal(loWrVal),
    .dlyWrEn(dlyWrEn), .dlyWrVal(dlyWrVal), .pgood(pgood)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    chkCnt++;
    if (got !== exp) begin
      errCnt++;
      $display("FAIL %s: pgood=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic writeRegs(input logic [9:0] up, input logic [9:0] lo, input logic [15:0] dly);
    upWrEn = 1'b1; upWrVal = up;
    loWrEn = 1'b1; loWrVal = lo;
    dlyWrEn = 1'b1; dlyWrVal = dly;
    edges(1);
    upWrEn = 1'b0; loWrEn = 1'b0; dlyWrEn = 1'b0;
  endtask

  task automatic dropOut();
    voutCode = '0; fault = 1'b0;
    edges(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: pgood=%b expected completion", pgood);
      $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    // R1: low in reset even with good conditions applied
    voutCode = 12'd1000;
    edges(3);
    check(pgood, 1'b0, "R1 during reset");
    rstN = 1'b1;
    edges(1);
    check(pgood, 1'b0, "R1 first cycle after reset");

    // R7: default delay of 1000 ticks -> rises at edge 1002
    dropOut();
    voutCode = 12'd1000;
    edges(1001);
    check(pgood, 1'b0, "R7 default delay not yet expired");
    edges(1);
    check(pgood, 1'b1, "R7 default delay expired");

    // table walk: default percentages, delay 0
    dlyWrEn = 1'b1; dlyWrVal = 16'd0;
    edges(1);
    dlyWrEn = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      targetCode = VEC[i][25:14];
      dropOut();
      voutCode = VEC[i][13:2];
      fault    = VEC[i][1];
      edges(2);
      check(pgood, VEC[i][0], $sformatf("R2/R3/R5 vector %0d", i));
    end

    // R4: zero-width window after writing both percentages to 0
    targetCode = 12'd500;
    dropOut();
    writeRegs(10'd0, 10'd0, 16'd0);
    voutCode = 12'd501;
    edges(2);
    check(pgood, 1'b0, "R4 upper edge narrowed to target");
    voutCode = 12'd500;
    edges(2);
    check(pgood, 1'b1, "R4 exact target inside");
    voutCode = 12'd499;
    #1;
    check(pgood, 1'b0, "R4 lower edge narrowed to target");

    // R6: delay 5 with tick every cycle -> 7 edges
    dropOut();
    writeRegs(10'd154, 10'd102, 16'd5);
    targetCode = 12'd1000;
    voutCode = 12'd1000;
    edges(6);
    check(pgood, 1'b0, "R6 before delay");
    edges(1);
    check(pgood, 1'b1, "R6 at delay");

    // R9: immediate release when voltage leaves window
    voutCode = 12'd1200;
    #1;
    check(pgood, 1'b0, "R9 same-cycle release");

    // R5: fault during good releases immediately
    voutCode = 12'd1000;
    edges(7);
    check(pgood, 1'b1, "R5 requalified");
    fault = 1'b1;
    #1;
    check(pgood, 1'b0, "R5 fault release");
    fault = 1'b0;

    // R8: interruption restarts the count
    dropOut();
    voutCode = 12'd1000;
    edges(4);
    voutCode = 12'd0;
    edges(1);
    voutCode = 12'd1000;
    edges(6);
    check(pgood, 1'b0, "R8 restart not yet done");
    edges(1);
    check(pgood, 1'b1, "R8 restart complete");

    // R10: no ticks, no progress
    dropOut();
    tick = 1'b0;
    voutCode = 12'd1000;
    edges(20);
    check(pgood, 1'b0, "R10 held without ticks");
    tick = 1'b1;
    edges(5);
    check(pgood, 1'b0, "R10 counting ticks");
    edges(1);
    check(pgood, 1'b1, "R10 ticks completed delay");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule